// File: doc/BRIEF.md
# Camera PHY Bring-up Sequencer

This block powers up a camera-side receive PHY by driving its register test port through a fixed programming sequence. Software or a parent controller gives it a lane bit rate in Mbps and a lane-enable value, then pulses a start input. The block looks up a frequency-band code for that rate and pulses the test-port clear for a timed interval. It then writes the clock-lane setting and the band code for each enabled data lane, ends with an address-only access that returns the port to normal operation, and finally releases shutdown and reset.

The block does not perform the individual test-port write itself. It passes address, data and an address-only flag to a separate write engine and holds the request until the engine reports that the write is done. A start with a zero rate or a zero lane value does not program the PHY. Instead it puts the PHY in standby, with shutdown and reset held low. The timed waits come from a cycle counter whose terminal count is the clock frequency in MHz multiplied by the wait length in microseconds.

Top module: `cam_phy_seq`

## Requirements
- R1: After reset, `busy`, `standby`, `rate_err`, `wr_req`, `tp_clr`, `tp_en`, `phy_shutdown_n` and `phy_reset_n` are all low.
- R2: Band lookup. A rate matches band k when it is strictly above edge k and no higher than edge k+1.
  - The edges, in Mbps, are: 80 90 100 110 130 140 150 170 180 200 220 240 250 270 300 330 360 400 450 500 550 600 650 700 750 800 850 900 950 1000.
  - The band codes, in hex, are: 00 10 20 01 11 21 02 12 22 03 13 23 04 14 05 15 25 06 16 07 17 08 18 09 19 29 39 0A 1A.
  - The data written to every data-lane register is the band code shifted left by one bit.
- R3: A rate that matches no band uses code 0. It also sets `rate_err` high until the next accepted start.
- R4: A start with `rate_mbps` equal to 0 or `lane_en` equal to 0 programs nothing. `standby` goes high, `phy_shutdown_n` and `phy_reset_n` go low, `busy` stays low and no `wr_req` appears.
- R5: When a bring-up is accepted, `tp_clk` goes high and stays high.
  - `tp_clr` is high for exactly WAIT cycles (WAIT = CLK_MHZ × WAIT_US).
  - The first write request comes at least WAIT cycles after `tp_clr` falls.
- R6: The writes are issued in this order:
  - address 0x34 with data 0x15;
  - address 0x44;
  - address 0x54, when `lane_en` ≥ 1;
  - addresses 0x84 and 0x94, when `lane_en` ≥ 4.
- R7: `wr_req` stays high, with `wr_addr`, `wr_data` and `wr_addr_only` stable, until `wr_done` is sampled. It falls on the edge that samples `wr_done`.
- R8: After the lane writes, one access to address 0x00 is issued with `wr_addr_only` high. Then `tp_en` falls. One cycle later `phy_shutdown_n` rises, and one cycle after that `phy_reset_n` rises.
- R9: `busy` rises on the edge that accepts a start and falls on the edge where `phy_reset_n` rises. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin bring-up or standby (sampled when idle) |
| rate_mbps | input | RATE_W | Requested lane bit rate in Mbps |
| lane_en | input | LANE_W | Lane-enable value |
| busy | output | 1 | Bring-up in progress |
| standby | output | 1 | PHY placed in standby by the last start |
| rate_err | output | 1 | Requested rate matched no band |
| tp_clk | output | 1 | Test-port clock level |
| tp_clr | output | 1 | Test-port clear |
| tp_en | output | 1 | Test-port enable for register access |
| wr_req | output | 1 | Write request to the write engine |
| wr_addr | output | AW | Test-port register address |
| wr_data | output | DW | Test-port write data |
| wr_addr_only | output | 1 | Access carries an address and no data |
| wr_done | input | 1 | Write engine finished the current access |
| phy_shutdown_n | output | 1 | PHY shutdown, active low |
| phy_reset_n | output | 1 | PHY reset, active low |

## Verification
`busy` and the clear pulse begin on the edge that accepts the start, so the bench samples them at the falling edge that follows the start cycle. The clear length is counted in falling-edge samples. Write requests are timed by a write-engine model that answers after a random 0 to 2 cycle delay, and the bench checks each request's fields on every sample until the answer. The release steps come one edge apart, so the bench records the sample index of each transition and compares the differences, not absolute times, because the write-engine latency varies.

// File: rtl/cps_pkg.sv
package cps_pkg;

   localparam int N_BANDS = 29;
   localparam int N_STEPS = 6;
   localparam int CODE_W  = 6;

   typedef enum logic [2:0] {
      S_IDLE, S_CLR, S_SETTLE, S_SEL, S_REQ, S_DROP, S_REL_SD, S_REL_RST
   } seq_state_t;

   localparam logic [7:0] A_CLK_LANE = 8'h34;
   localparam logic [7:0] V_CLK_LANE = 8'h15;
   localparam logic [7:0] A_LANE0    = 8'h44;
   localparam logic [7:0] A_LANE1    = 8'h54;
   localparam logic [7:0] A_LANE2    = 8'h84;
   localparam logic [7:0] A_LANE3    = 8'h94;
   localparam logic [7:0] A_NORMAL   = 8'h00;

   // band edge k (Mbps); band k spans (edge k, edge k+1]
   function automatic logic [10:0] band_edge(input int idx);
      case (idx)
         0: return 11'd80;    1: return 11'd90;    2: return 11'd100;
         3: return 11'd110;   4: return 11'd130;   5: return 11'd140;
         6: return 11'd150;   7: return 11'd170;   8: return 11'd180;
         9: return 11'd200;  10: return 11'd220;  11: return 11'd240;
        12: return 11'd250;  13: return 11'd270;  14: return 11'd300;
        15: return 11'd330;  16: return 11'd360;  17: return 11'd400;
        18: return 11'd450;  19: return 11'd500;  20: return 11'd550;
        21: return 11'd600;  22: return 11'd650;  23: return 11'd700;
        24: return 11'd750;  25: return 11'd800;  26: return 11'd850;
        27: return 11'd900;  28: return 11'd950;  default: return 11'd1000;
      endcase
   endfunction

   function automatic logic [CODE_W-1:0] band_code(input int idx);
      case (idx)
         0: return 6'h00;   1: return 6'h10;   2: return 6'h20;
         3: return 6'h01;   4: return 6'h11;   5: return 6'h21;
         6: return 6'h02;   7: return 6'h12;   8: return 6'h22;
         9: return 6'h03;  10: return 6'h13;  11: return 6'h23;
        12: return 6'h04;  13: return 6'h14;  14: return 6'h05;
        15: return 6'h15;  16: return 6'h25;  17: return 6'h06;
        18: return 6'h16;  19: return 6'h07;  20: return 6'h17;
        21: return 6'h08;  22: return 6'h18;  23: return 6'h09;
        24: return 6'h19;  25: return 6'h29;  26: return 6'h39;
        27: return 6'h0A;  default: return 6'h1A;
      endcase
   endfunction

endpackage

// File: rtl/cps_rate_map.sv
module cps_rate_map
   import cps_pkg::*;
#(
   parameter int RATE_W = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [RATE_W-1:0]    rate,
   output logic [CODE_W-1:0]    code,
   output logic                 err
);

   generate
      if (RATE_W < 10 || RATE_W > 31) begin : g_bad_rate_w
         $error("cps_rate_map: RATE_W must lie in 10..31");
      end
   endgenerate

   logic                hit;
   logic [CODE_W-1:0]   pick;

   // priority search: lowest matching band wins
   always_comb begin
      hit  = 1'b0;
      pick = '0;
      for (int i = N_BANDS - 1; i >= 0; i--) begin
         if ((32'(rate) > 32'(band_edge(i))) && (32'(rate) <= 32'(band_edge(i + 1)))) begin
            hit  = 1'b1;
            pick = band_code(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         err  <= 1'b0;
      end else if (load) begin
         code <= pick;
         err  <= !hit;
      end
   end

   // R3
   fallback_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (code == '0));

endmodule

// File: rtl/cps_delay.sv
module cps_delay #(
   parameter int CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("cps_delay: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             run;

   assign expired = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= CNT_W'(CYCLES - 1);
         run <= 1'b1;
      end else if (expired) begin
         run <= 1'b0;
      end else if (run) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R5
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !expired) |=> (run && (cnt == $past(cnt) - 1'b1)));

endmodule

// File: rtl/cps_step_rom.sv
module cps_step_rom
   import cps_pkg::*;
#(
   parameter int LANE_W = 4,
   parameter int AW     = 8,
   parameter int DW     = 8
) (
   input  logic [2:0]          step,
   input  logic [LANE_W-1:0]   lanes,
   input  logic [CODE_W-1:0]   code,
   output logic [AW-1:0]       addr,
   output logic [DW-1:0]       data,
   output logic                addr_only,
   output logic                enable
);

   logic [DW-1:0] lane_val;

   generate
      if (DW < CODE_W + 1) begin : g_bad_dw
         $error("cps_step_rom: DW too narrow for the shifted band code");
      end
      if (AW < 8) begin : g_bad_aw
         $error("cps_step_rom: AW must be at least 8");
      end
      if (LANE_W < 3) begin : g_bad_lane_w
         $error("cps_step_rom: LANE_W must be at least 3");
      end
      if (DW == CODE_W + 1) begin : g_exact
         assign lane_val = {code, 1'b0};
      end else begin : g_wide
         assign lane_val = {{(DW - CODE_W - 1){1'b0}}, code, 1'b0};
      end
   endgenerate

   always_comb begin
      addr      = '0;
      data      = '0;
      addr_only = 1'b0;
      enable    = 1'b0;
      case (step)
         3'd0: begin
            addr   = AW'(A_CLK_LANE);
            data   = DW'(V_CLK_LANE);
            enable = 1'b1;
         end
         3'd1: begin
            addr   = AW'(A_LANE0);
            data   = lane_val;
            enable = 1'b1;
         end
         3'd2: begin
            addr   = AW'(A_LANE1);
            data   = lane_val;
            enable = (lanes >= LANE_W'(1));
         end
         3'd3: begin
            addr   = AW'(A_LANE2);
            data   = lane_val;
            enable = (lanes >= LANE_W'(4));
         end
         3'd4: begin
            addr   = AW'(A_LANE3);
            data   = lane_val;
            enable = (lanes >= LANE_W'(4));
         end
         3'd5: begin
            addr      = AW'(A_NORMAL);
            addr_only = 1'b1;
            enable    = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/cam_phy_seq.sv
module cam_phy_seq
   import cps_pkg::*;
#(
   parameter int CLK_MHZ = 200,
   parameter int WAIT_US = 100,
   parameter int RATE_W  = 11,
   parameter int LANE_W  = 4,
   parameter int AW      = 8,
   parameter int DW      = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [RATE_W-1:0]   rate_mbps,
   input  logic [LANE_W-1:0]   lane_en,
   output logic                busy,
   output logic                standby,
   output logic                rate_err,
   output logic                tp_clk,
   output logic                tp_clr,
   output logic                tp_en,
   output logic                wr_req,
   output logic [AW-1:0]       wr_addr,
   output logic [DW-1:0]       wr_data,
   output logic                wr_addr_only,
   input  logic                wr_done,
   output logic                phy_shutdown_n,
   output logic                phy_reset_n
);

   localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
   localparam int LAST_STEP = N_STEPS - 1;

   generate
      if (CLK_MHZ < 1 || WAIT_US < 1) begin : g_bad_timing
         $error("cam_phy_seq: CLK_MHZ and WAIT_US must be positive");
      end
   endgenerate

   seq_state_t          state;
   logic [2:0]          step;
   logic [LANE_W-1:0]   lanes_q;
   logic [CODE_W-1:0]   code;
   logic                accept, go_standby, tmr_load, tmr_exp;
   logic [AW-1:0]       rom_addr;
   logic [DW-1:0]       rom_data;
   logic                rom_ao, rom_en;

   assign accept     = (state == S_IDLE) && start && (rate_mbps != '0) && (lane_en != '0);
   assign go_standby = (state == S_IDLE) && start && ((rate_mbps == '0) || (lane_en == '0));
   assign tmr_load   = accept || ((state == S_CLR) && tmr_exp);

   cps_rate_map #(.RATE_W(RATE_W)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .rate  (rate_mbps),
      .code  (code),
      .err   (rate_err)
   );

   cps_delay #(.CYCLES(WAIT_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .expired (tmr_exp)
   );

   cps_step_rom #(.LANE_W(LANE_W), .AW(AW), .DW(DW)) u_rom (
      .step      (step),
      .lanes     (lanes_q),
      .code      (code),
      .addr      (rom_addr),
      .data      (rom_data),
      .addr_only (rom_ao),
      .enable    (rom_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= S_IDLE;
         step           <= '0;
         lanes_q        <= '0;
         busy           <= 1'b0;
         standby        <= 1'b0;
         tp_clk         <= 1'b0;
         tp_clr         <= 1'b0;
         tp_en          <= 1'b0;
         wr_req         <= 1'b0;
         wr_addr        <= '0;
         wr_data        <= '0;
         wr_addr_only   <= 1'b0;
         phy_shutdown_n <= 1'b0;
         phy_reset_n    <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (accept) begin
                  lanes_q        <= lane_en;
                  busy           <= 1'b1;
                  standby        <= 1'b0;
                  tp_clk         <= 1'b1;
                  tp_clr         <= 1'b1;
                  phy_shutdown_n <= 1'b0;
                  phy_reset_n    <= 1'b0;
                  state          <= S_CLR;
               end else if (go_standby) begin
                  standby        <= 1'b1;
                  phy_shutdown_n <= 1'b0;
                  phy_reset_n    <= 1'b0;
               end
            end
            S_CLR: begin
               if (tmr_exp) begin
                  tp_clr <= 1'b0;
                  state  <= S_SETTLE;
               end
            end
            S_SETTLE: begin
               if (tmr_exp) begin
                  step  <= '0;
                  tp_en <= 1'b1;
                  state <= S_SEL;
               end
            end
            S_SEL: begin
               if (rom_en) begin
                  wr_addr      <= rom_addr;
                  wr_data      <= rom_data;
                  wr_addr_only <= rom_ao;
                  wr_req       <= 1'b1;
                  state        <= S_REQ;
               end else begin
                  step <= step + 1'b1;
               end
            end
            S_REQ: begin
               if (wr_done) begin
                  wr_req <= 1'b0;
                  if (step == 3'(LAST_STEP)) begin
                     state <= S_DROP;
                  end else begin
                     step  <= step + 1'b1;
                     state <= S_SEL;
                  end
               end
            end
            S_DROP: begin
               tp_en <= 1'b0;
               state <= S_REL_SD;
            end
            S_REL_SD: begin
               phy_shutdown_n <= 1'b1;
               state          <= S_REL_RST;
            end
            S_REL_RST: begin
               phy_reset_n <= 1'b1;
               busy        <= 1'b0;
               state       <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_addr_only)));

   // R7
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_done) |=> !wr_req);

   // R5
   req_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (!tp_clr && tp_clk && tp_en));

   // R8
   release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_shutdown_n) |=> (phy_reset_n && !tp_en));

   // R9
   busy_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!phy_reset_n && !phy_shutdown_n == !phy_shutdown_n));

   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($rose(phy_reset_n) && phy_shutdown_n));

   // R4
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (!busy && !wr_req && !phy_reset_n));

endmodule

// File: tb/cam_phy_seq_test.sv
`timescale 1ns/1ps
module cam_phy_seq_test;

   localparam int W = 8;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start = 0;
   logic [10:0] rate = 0;
   logic [3:0]  lane = 0;
   logic        wr_done = 0;
   logic        busy, standby, rate_err, tp_clk, tp_clr, tp_en;
   logic        wr_req, wr_addr_only, phy_shutdown_n, phy_reset_n;
   logic [7:0]  wr_addr, wr_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   cam_phy_seq #(.CLK_MHZ(1), .WAIT_US(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_mbps(rate), .lane_en(lane),
      .busy(busy), .standby(standby), .rate_err(rate_err), .tp_clk(tp_clk),
      .tp_clr(tp_clr), .tp_en(tp_en), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_addr_only(wr_addr_only), .wr_done(wr_done),
      .phy_shutdown_n(phy_shutdown_n), .phy_reset_n(phy_reset_n)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int edge_of(input int k);
      int e[30] = '{80, 90, 100, 110, 130, 140, 150, 170, 180, 200, 220, 240, 250, 270, 300,
                    330, 360, 400, 450, 500, 550, 600, 650, 700, 750, 800, 850, 900, 950, 1000};
      return e[k];
   endfunction

   function automatic int code_of(input int k);
      int c[29] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03, 'h13, 'h23,
                    'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07, 'h17, 'h08, 'h18, 'h09,
                    'h19, 'h29, 'h39, 'h0A, 'h1A};
      return c[k];
   endfunction

   // returns band code, or -1 when no band matches
   function automatic int lookup(input int r);
      for (int k = 0; k < 29; k++)
         if (r > edge_of(k) && r <= edge_of(k + 1)) return code_of(k);
      return -1;
   endfunction

   task automatic bringup(input int r, input int l, input bit inject);
      int n = 0;
      int ra[8], rd[8];
      bit rao[8];
      int ea[8], ed[8];
      bit eao[8];
      int en = 0;
      int clr_hi, t_clr_f = -1, t_first = -1, t_en_f = -1, t_sd = -1, t_rst = -1, t_busy_f = -1;
      bit pend = 0, drv = 0, stable_ok = 1;
      int dly = 0, cyc = 0, code, lanedata;
      bit p_clr, p_en, p_sd, p_rst;

      code = lookup(r);
      lanedata = ((code < 0) ? 0 : code) << 1;
      ea[en] = 'h34; ed[en] = 'h15; eao[en] = 0; en++;
      ea[en] = 'h44; ed[en] = lanedata; eao[en] = 0; en++;
      if (l >= 1) begin ea[en] = 'h54; ed[en] = lanedata; eao[en] = 0; en++; end
      if (l >= 4) begin
         ea[en] = 'h84; ed[en] = lanedata; eao[en] = 0; en++;
         ea[en] = 'h94; ed[en] = lanedata; eao[en] = 0; en++;
      end
      ea[en] = 'h00; ed[en] = 0; eao[en] = 1; en++;

      @(negedge clk); start = 1; rate = 11'(r); lane = 4'(l);
      @(negedge clk); start = 0;
      chk(busy == 1, "R9", "busy after start", busy, 1);
      chk(tp_clk == 1 && phy_reset_n == 0 && phy_shutdown_n == 0, "R5", "clock high, PHY held", tp_clk, 1);
      clr_hi = tp_clr ? 1 : 0;
      p_clr = tp_clr; p_en = tp_en; p_sd = phy_shutdown_n; p_rst = phy_reset_n;

      while (cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (inject && cyc == 3) begin start = 1; rate = 11'd700; lane = 4'd15; end
         else if (inject && cyc == 4) start = 0;
         if (tp_clr) clr_hi++;
         if (p_clr && !tp_clr) t_clr_f = cyc;
         if (drv) begin
            wr_done = 0; drv = 0; pend = 0;
         end else if (pend) begin
            if (!wr_req || wr_addr != 8'(ra[n-1]) || wr_addr_only != rao[n-1] ||
                (!rao[n-1] && wr_data != 8'(rd[n-1]))) stable_ok = 0;
            if (dly == 0) begin wr_done = 1; drv = 1; end
            else dly--;
         end else if (wr_req) begin
            if (n < 8) begin ra[n] = wr_addr; rd[n] = wr_data; rao[n] = wr_addr_only; end
            n++;
            if (t_first < 0) t_first = cyc;
            pend = 1;
            dly = $urandom % 3;
            if (dly == 0) begin wr_done = 1; drv = 1; end
            else dly--;
         end
         if (p_en && !tp_en) t_en_f = cyc;
         if (!p_sd && phy_shutdown_n) t_sd = cyc;
         if (!p_rst && phy_reset_n) t_rst = cyc;
         if (!busy) begin t_busy_f = cyc; break; end
         p_clr = tp_clr; p_en = tp_en; p_sd = phy_shutdown_n; p_rst = phy_reset_n;
      end
      wr_done = 0;

      chk(t_busy_f >= 0, "R9", "bring-up completed", t_busy_f, 1);
      chk(rate_err == (code < 0), "R3", "rate_err", rate_err, int'(code < 0));
      chk(n == en, "R6", "write count", n, en);
      for (int i = 0; i < en && i < n && i < 8; i++) begin
         chk(ra[i] == ea[i], "R6", $sformatf("write %0d address", i), ra[i], ea[i]);
         chk(rao[i] == eao[i], "R8", $sformatf("write %0d address-only flag", i), rao[i], eao[i]);
         if (!eao[i]) chk(rd[i] == ed[i], "R2", $sformatf("write %0d data rate %0d", i, r), rd[i], ed[i]);
      end
      chk(clr_hi == W, "R5", "clear length", clr_hi, W);
      chk(t_first - t_clr_f >= W, "R5", "settle before first write", t_first - t_clr_f, W);
      chk(stable_ok, "R7", "request held stable until done", stable_ok, 1);
      chk(t_sd == t_en_f + 1, "R8", "shutdown release follows enable drop", t_sd - t_en_f, 1);
      chk(t_rst == t_sd + 1, "R8", "reset release follows shutdown release", t_rst - t_sd, 1);
      chk(t_busy_f == t_rst, "R9", "busy ends with reset release", t_busy_f - t_rst, 0);
      chk(phy_shutdown_n && phy_reset_n && tp_clk && !standby, "R8", "final PHY state", phy_reset_n, 1);
   endtask

   task automatic standby_req(input int r, input int l);
      @(negedge clk); start = 1; rate = 11'(r); lane = 4'(l);
      @(negedge clk); start = 0;
      for (int i = 0; i < 5; i++) begin
         chk(!wr_req && !busy, "R4", "no programming in standby", wr_req, 0);
         @(negedge clk);
      end
      chk(standby == 1, "R4", "standby flag", standby, 1);
      chk(!phy_shutdown_n && !phy_reset_n, "R4", "PHY held in standby", phy_shutdown_n, 0);
   endtask

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !standby && !rate_err && !wr_req && !tp_clr && !tp_en, "R1", "idle outputs after reset", busy, 0);
      chk(!phy_shutdown_n && !phy_reset_n, "R1", "PHY held after reset", phy_reset_n, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!busy && !wr_req && !phy_reset_n, "R1", "still idle after reset release", busy, 0);

      // directed band edges and gating
      bringup(90, 1, 0);
      bringup(91, 4, 0);
      bringup(81, 2, 0);
      bringup(1000, 15, 0);
      bringup(80, 4, 0);     // R3 below table
      bringup(1001, 3, 0);   // R3 above table
      standby_req(0, 4);     // R4 zero rate
      bringup(360, 5, 1);    // R9 start while busy is ignored
      standby_req(500, 0);   // R4 zero lanes
      bringup(951, 1, 0);

      for (int t = 0; t < 24; t++) begin
         bringup(1 + ($urandom % 1100), 1 + ($urandom % 15), ($urandom % 4) == 0);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule